// File: doc/BRIEF.md
# Five-State Sequence Counter with Selectable Excitation

This block is a synchronous three-bit counter whose state walks a fixed loop of five codes rather than the binary order. The state is read as C B A, with C the most significant bit. While counting is enabled, each rising clock edge moves the state one step along the loop 000, 100, 111, 010, 011 and then back to 000.

The next state is not written directly into the register. A target code is worked out for each bit. That target is turned into drive signals for a chosen storage style: toggle, set/clear or J/K. The storage style's own update rule is then applied to those drive signals. A parameter picks the storage style. All three styles produce the same sequence at the output, so the choice only changes the internal logic. The codes 001, 101 and 110 are not part of the loop. Each of them is steered into the loop on its next enabled step, so a disturbed counter never locks up.

Top module: `seq5_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 000 after that edge, whatever the values of `en` and the present state.
- R2: With `rst` low and `en` high, each edge advances the state along 000 -> 100 -> 111 -> 010 -> 011 -> 000, with bit order C B A as state_o[2:0].
- R3: With `rst` low and `en` low, the state keeps its value across the edge. This holds for unused codes as well.
- R4: With `en` high, the unused codes move in one edge to loop members: 001 goes to 011, 101 goes to 100 and 110 goes to 010.
- R5: Instances built with STORE_KIND 0 (toggle), 1 (set/clear) and 2 (J/K) give identical `state_o` for identical inputs and starting state.
- R6: In set/clear mode (STORE_KIND 1), no bit ever has its set and clear drives active at the same time, and the output still follows R2 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear to 000 |
| en | input | 1 | Count enable; low holds the state |
| state_o | output | 3 | Present state, bits C B A |

## Verification
Three instances, one per storage style, run in lockstep against a next-state table that the bench holds. The stimulus covers more than three full laps of the loop, which shows whether any transition is wrong in any style. It also includes stretches with the enable low, which separate a true hold from a stray step, and a reset asserted mid-loop, which shows that clearing wins over counting. Each unused code is then placed into every instance and stepped once with the enable high and once with it low. This shows both the exact recovery target and that an idle counter does not wander out of an unused code.

// File: rtl/seq5_pkg.sv
package seq5_pkg;

    localparam int SEQ_W = 3;

    localparam int KIND_TOGGLE = 0;
    localparam int KIND_SETCLR = 1;
    localparam int KIND_JK     = 2;

    // Per-bit drive pair: primary (T, S or J) and secondary (unused, R or K)
    typedef struct packed {
        logic [SEQ_W-1:0] pri;
        logic [SEQ_W-1:0] sec;
    } drive_t;

    typedef struct packed {
        logic [SEQ_W-1:0] code;
    } ctr_t;

endpackage

// File: rtl/seq5_target.sv
module seq5_target
    import seq5_pkg::*;
(
    input  logic [SEQ_W-1:0] cur_i,
    output logic [SEQ_W-1:0] tgt_o
);
    // Loop: 000->100->111->010->011->000; spare codes resolved into the loop
    always_comb begin
        unique case (cur_i)
            3'b000:  tgt_o = 3'b100;
            3'b100:  tgt_o = 3'b111;
            3'b111:  tgt_o = 3'b010;
            3'b010:  tgt_o = 3'b011;
            3'b011:  tgt_o = 3'b000;
            3'b001:  tgt_o = 3'b011;
            3'b101:  tgt_o = 3'b100;
            default: tgt_o = 3'b010; // 3'b110
        endcase
    end
endmodule

// File: rtl/seq5_excite.sv
module seq5_excite
    import seq5_pkg::*;
#(
    parameter int KIND = KIND_TOGGLE
) (
    input  logic [SEQ_W-1:0] cur_i,
    input  logic [SEQ_W-1:0] tgt_o_i,
    output drive_t           drv_o
);
    for (genvar b = 0; b < SEQ_W; b++) begin : g_bit
        if (KIND == KIND_SETCLR) begin : g_sc
            // Don't-cares resolved to 0: set only on 0->1, clear only on 1->0
            assign drv_o.pri[b] = ~cur_i[b] &  tgt_o_i[b];
            assign drv_o.sec[b] =  cur_i[b] & ~tgt_o_i[b];
        end else if (KIND == KIND_JK) begin : g_jk
            assign drv_o.pri[b] = ~cur_i[b] &  tgt_o_i[b];
            assign drv_o.sec[b] =  cur_i[b] & ~tgt_o_i[b];
        end else begin : g_t
            assign drv_o.pri[b] = cur_i[b] ^ tgt_o_i[b];
            assign drv_o.sec[b] = 1'b0;
        end
    end
endmodule

// File: rtl/seq5_store.sv
module seq5_store
    import seq5_pkg::*;
#(
    parameter int KIND = KIND_TOGGLE
) (
    input  logic [SEQ_W-1:0] cur_i,
    input  drive_t           drv_i,
    output logic [SEQ_W-1:0] nxt_o
);
    // Characteristic update rule of the chosen storage element
    for (genvar b = 0; b < SEQ_W; b++) begin : g_bit
        if (KIND == KIND_SETCLR) begin : g_sc
            assign nxt_o[b] = drv_i.pri[b] | (cur_i[b] & ~drv_i.sec[b]);
        end else if (KIND == KIND_JK) begin : g_jk
            assign nxt_o[b] = (drv_i.pri[b] & ~cur_i[b]) | (~drv_i.sec[b] & cur_i[b]);
        end else begin : g_t
            assign nxt_o[b] = cur_i[b] ^ drv_i.pri[b];
        end
    end
endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
    import seq5_pkg::*;
#(
    parameter int STORE_KIND = KIND_TOGGLE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [SEQ_W-1:0] state_o
);
    ctr_t             ctr_d, ctr_q;
    logic [SEQ_W-1:0] tgt_w;
    logic [SEQ_W-1:0] step_w;
    drive_t           drv_w;

    seq5_target u_tgt (
        .cur_i (ctr_q.code),
        .tgt_o (tgt_w)
    );

    seq5_excite #(.KIND(STORE_KIND)) u_exc (
        .cur_i   (ctr_q.code),
        .tgt_o_i (tgt_w),
        .drv_o   (drv_w)
    );

    seq5_store #(.KIND(STORE_KIND)) u_sto (
        .cur_i (ctr_q.code),
        .drv_i (drv_w),
        .nxt_o (step_w)
    );

    always_comb begin
        ctr_d = ctr_q;
        if (rst) begin
            ctr_d.code = '0;
        end else if (en) begin
            ctr_d.code = step_w;
        end
    end

    always_ff @(posedge clk) begin
        ctr_q <= ctr_d;
    end

    assign state_o = ctr_q.code;
endmodule

// File: rtl/seq5_checker.sv
module seq5_checker
    import seq5_pkg::*;
#(
    parameter int KIND = KIND_TOGGLE
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [SEQ_W-1:0] state,
    input logic [SEQ_W-1:0] pri,
    input logic [SEQ_W-1:0] sec
);
    // R2
    loop_a_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state == 3'b000) |=> state == 3'b100);
    // R2
    loop_b_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state == 3'b111) |=> state == 3'b010);
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state));
    // R4
    spare_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (en && (state == 3'b001 || state == 3'b101 || state == 3'b110))
        |=> !(state == 3'b001 || state == 3'b101 || state == 3'b110));
    // R6
    no_set_clr_clash_chk: assert property (@(posedge clk) disable iff (rst)
        (KIND != KIND_SETCLR) || ((pri & sec) == '0));
endmodule

bind seq5_counter seq5_checker #(.KIND(STORE_KIND)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .state (state_o),
    .pri   (drv_w.pri),
    .sec   (drv_w.sec)
);

// File: tb/sim_seq5_counter.sv
module sim_seq5_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [2:0] q0, q1, q2;
    int         total = 0;
    int         bad   = 0;
    bit         done  = 1'b0;

    always #2 clk = ~clk;

    seq5_counter #(.STORE_KIND(0)) u0 (.clk(clk), .rst(rst), .en(en), .state_o(q0));
    seq5_counter #(.STORE_KIND(1)) u1 (.clk(clk), .rst(rst), .en(en), .state_o(q1));
    seq5_counter #(.STORE_KIND(2)) u2 (.clk(clk), .rst(rst), .en(en), .state_o(q2));

    function automatic logic [2:0] want_next(input logic [2:0] c);
        case (c)
            3'b000:  return 3'b100;
            3'b100:  return 3'b111;
            3'b111:  return 3'b010;
            3'b010:  return 3'b011;
            3'b011:  return 3'b000;
            3'b001:  return 3'b011;
            3'b101:  return 3'b100;
            default: return 3'b010;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // toggle style on u0, set/clear (R6) on u1, J/K on u2; R5 agreement
    task automatic chk_all(input string tag, input logic [2:0] exp);
        chk({tag, " toggle"}, q0, exp);
        chk({tag, " R6 setclr"}, q1, exp);
        chk({tag, " jk"}, q2, exp);
        chk("R5 toggle vs setclr", q1, q0);
        chk("R5 toggle vs jk", q2, q0);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_up();
    end

    initial begin
        logic [2:0] exp;
        logic [2:0] spare [3];
        spare[0] = 3'b001; spare[1] = 3'b101; spare[2] = 3'b110;

        step();
        step();
        chk_all("R1 reset", 3'b000);

        rst = 1'b0; en = 1'b1;
        exp = 3'b000;
        for (int i = 0; i < 17; i++) begin
            step();
            exp = want_next(exp);
            chk_all("R2 loop", exp);
        end

        en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk_all("R3 hold", exp);
        end

        en = 1'b1;
        for (int i = 0; i < 2; i++) begin
            step();
            exp = want_next(exp);
            chk_all("R2 resume", exp);
        end

        rst = 1'b1;
        step();
        chk_all("R1 mid-loop reset", 3'b000);

        for (int k = 0; k < 3; k++) begin
            // enabled recovery
            rst = 1'b1; en = 1'b1;
            @(posedge clk);
            #1;
            force u0.ctr_q = spare[k];
            force u1.ctr_q = spare[k];
            force u2.ctr_q = spare[k];
            #1;
            release u0.ctr_q;
            release u1.ctr_q;
            release u2.ctr_q;
            rst = 1'b0;
            #1;
            chk_all("R4 placed", spare[k]);
            step();
            chk_all("R4 exit", want_next(spare[k]));
            step();
            chk_all("R2 after exit", want_next(want_next(spare[k])));

            // idle in a spare code
            rst = 1'b1; en = 1'b0;
            @(posedge clk);
            #1;
            force u0.ctr_q = spare[k];
            force u1.ctr_q = spare[k];
            force u2.ctr_q = spare[k];
            #1;
            release u0.ctr_q;
            release u1.ctr_q;
            release u2.ctr_q;
            rst = 1'b0;
            #1;
            step();
            chk_all("R3 spare hold", spare[k]);
            en = 1'b1;
            step();
            chk_all("R4 exit after idle", want_next(spare[k]));
        end

        finish_up();
    end
endmodule